// File: doc/BRIEF.md
# Descriptor Ring Producer

This block fills a ring of DMA descriptors held in a local synchronous RAM and tells the data mover how much work is waiting. Each request asks for either a copy or a fill. A copy request carries a source address. A fill request carries a pattern instead. Every request also carries a destination, a length, a fence flag and a submit flag. An accepted request is written into the next ring slot, and the block returns that slot's 16-bit index straight away. A full ring rejects the request.

When the block submits work, it updates a doorbell register with the number of descriptors handed over since the last recovery point. It also keeps a running total of submitted operations. On the completion side, the block takes the address that the data mover wrote back. It turns that address into the index of the last retired descriptor, counts the newly retired entries up to a limit set by the caller, and advances its read index by that count. A recovery strobe moves the recovery point to the current read index. After recovery, a written-back address of zero is read as "nothing past the recovery point".

Top module: `dring_producer`

## Requirements
- R1: The ring depth is the requested depth rounded up to a power of two and clamped to the range 32..4096. With the default request of 24, the ring has 32 slots, and `cap_o` reads 31 after reset.
- R2: The next-pointer read back for slot i equals `RING_BASE + ((i+1) mod depth)*64`, so the last slot links back to slot 0.
- R3: The free space `cap_o` equals `mask + read - write` in 16-bit arithmetic. When a request arrives with zero space, it is rejected with `req_full_o`=1 and `req_ok_o`=0. A rejected request writes nothing, sets no fence and does not advance the write index.
- R4: The stored opcode is 0 for copy and 1 for fill. A fill stores its pattern in the source field. Every written descriptor has its completion-update bit set to 1.
- R5: A fenced request sets the fence bit of the slot at `(write-1)&mask`, the slot before its own. Its own slot is stored with the fence bit clear.
- R6: On a submit, coming either from the request's submit flag or from `submit_i`, `db_valid_o` pulses one cycle later. At that point `db_count_o` equals `next_write - offset`, and `sub_cnt_o` has grown by `next_write - last_write`. A second submit with no new requests adds 0.
- R7: The retired index is `(status_address - RING_BASE) >> 6`, where the status address is `cmp_status_i` with its low 3 state bits cleared. If that address is zero, the retired index is `offset - 1`.
- R8: `cmp_count_o` equals `(retired + 1 - read) & mask`, capped at `cmp_max_i`. `cmp_last_o` equals `read + count - 1`. A strobe on `cmp_valid_i` advances the read index by the count.
- R9: Each accepted request returns `req_idx_o`, which equals `next_write - 1` after the increment, and the write index advances by exactly one.
- R10: A submit flag on a request updates the doorbell at the same clock edge as that request's descriptor write, so the doorbell count includes the new descriptor.
- R11: `recover_i` sets the offset to the current read index. Later doorbell counts are measured from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 1 | 0 = copy, 1 = fill |
| req_src_i | input | ADDR_W | Source address, or fill pattern |
| req_dst_i | input | ADDR_W | Destination address |
| req_len_i | input | LEN_W | Transfer length |
| req_fence_i | input | 1 | Fence against earlier operations |
| req_submit_i | input | 1 | Ring the doorbell together with this request |
| req_ok_o | output | 1 | Request accepted |
| req_full_o | output | 1 | Request rejected, ring full |
| req_idx_o | output | IDX_W | Ring index of the accepted request |
| submit_i | input | 1 | Standalone doorbell request |
| recover_i | input | 1 | Set the offset to the read index |
| db_valid_o | output | 1 | Doorbell write pulse |
| db_count_o | output | IDX_W | Doorbell value |
| sub_cnt_o | output | CNT_W | Submitted operations total |
| cap_o | output | IDX_W | Free ring slots |
| cmp_valid_i | input | 1 | Consume completions |
| cmp_status_i | input | ADDR_W | Written-back status address with state bits |
| cmp_max_i | input | IDX_W | Maximum entries to retire |
| cmp_count_o | output | IDX_W | Newly retired count |
| cmp_last_o | output | IDX_W | Index of the last retired entry |
| rd_idx_i | input | IDX_W | Slot to read back |
| rd_op_o | output | 1 | Read-back opcode |
| rd_comp_o | output | 1 | Read-back completion-update bit |
| rd_fence_o | output | 1 | Read-back fence bit |
| rd_len_o | output | LEN_W | Read-back length |
| rd_src_o | output | ADDR_W | Read-back source or pattern |
| rd_dst_o | output | ADDR_W | Read-back destination |
| rd_next_o | output | ADDR_W | Read-back next pointer |

## Verification
The hardest state to reach is a full ring that still holds live entries, combined with a doorbell offset that is no longer zero. Reaching it takes several steps. The stimulus first retires part of the ring through written-back addresses. It then keeps issuing requests until the space reaches zero, and sends one more fenced request that must be rejected. The read port then shows that neither the target slot nor its neighbour's fence bit changed. After that, a recovery strobe followed by a zero status address checks the offset-minus-one rule, and a standalone submit checks that the doorbell count now starts from the new offset.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int DESC_SHIFT = 6;
  localparam int MIN_SLOTS  = 32;
  localparam int MAX_SLOTS  = 4096;
  typedef enum logic {OP_COPY = 1'b0, OP_FILL = 1'b1} op_e;
endpackage

// File: rtl/dring_ram.sv
module dring_ram #(
  parameter int DEPTH  = 32,
  parameter int AW     = 5,
  parameter int DATA_W = 98
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fset_i,
  input  logic [AW-1:0]     faddr_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rfence_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  fence_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // fence bits live beside the array so the previous slot can be flagged in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fence_q  <= '0;
      rfence_o <= 1'b0;
    end else begin
      if (we_i)   fence_q[waddr_i] <= 1'b0;
      if (fset_i) fence_q[faddr_i] <= 1'b1;
      rfence_o <= fence_q[raddr_i];
    end
  end

  a_r5_fence_other_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && fset_i) |-> (waddr_i != faddr_i));
endmodule

// File: rtl/dring_retire.sv
module dring_retire
  import dring_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                IDX_W     = 16,
  parameter logic [ADDR_W-1:0] RING_BASE = 'h10000,
  parameter logic [IDX_W-1:0]  MASK      = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] status_i,
  input  logic [IDX_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  read_i,
  input  logic [IDX_W-1:0]  max_i,
  output logic [IDX_W-1:0]  count_o,
  output logic [IDX_W-1:0]  last_o
);
  logic [ADDR_W-1:0] addr, diff;
  logic [IDX_W-1:0]  retired, raw;

  always_comb begin
    addr    = {status_i[ADDR_W-1:3], 3'b000};
    diff    = addr - RING_BASE;
    retired = (addr == '0) ? offset_i - 1'b1 : IDX_W'(diff >> DESC_SHIFT);
    raw     = (retired + 1'b1 - read_i) & MASK;
    count_o = (raw > max_i) ? max_i : raw;
    last_o  = read_i + count_o - 1'b1;
  end

  a_r8_count_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= max_i) && (count_o <= MASK));
endmodule

// File: rtl/dring_producer.sv
module dring_producer
  import dring_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                LEN_W     = 16,
  parameter int                IDX_W     = 16,
  parameter int                CNT_W     = 32,
  parameter int                RING_REQ  = 24,
  parameter logic [ADDR_W-1:0] RING_BASE = 'h10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [ADDR_W-1:0] req_src_i,
  input  logic [ADDR_W-1:0] req_dst_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_fence_i,
  input  logic              req_submit_i,
  output logic              req_ok_o,
  output logic              req_full_o,
  output logic [IDX_W-1:0]  req_idx_o,
  input  logic              submit_i,
  input  logic              recover_i,
  output logic              db_valid_o,
  output logic [IDX_W-1:0]  db_count_o,
  output logic [CNT_W-1:0]  sub_cnt_o,
  output logic [IDX_W-1:0]  cap_o,
  input  logic              cmp_valid_i,
  input  logic [ADDR_W-1:0] cmp_status_i,
  input  logic [IDX_W-1:0]  cmp_max_i,
  output logic [IDX_W-1:0]  cmp_count_o,
  output logic [IDX_W-1:0]  cmp_last_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_op_o,
  output logic              rd_comp_o,
  output logic              rd_fence_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_dst_o,
  output logic [ADDR_W-1:0] rd_next_o
);
  localparam int RING_CLAMP = (RING_REQ < MIN_SLOTS) ? MIN_SLOTS :
                              (RING_REQ > MAX_SLOTS) ? MAX_SLOTS : RING_REQ;
  localparam int RING_AW = $clog2(RING_CLAMP);
  localparam int RING_N  = 1 << RING_AW;
  localparam logic [IDX_W-1:0] MASK = IDX_W'(RING_N - 1);
  localparam int DATA_W  = 2 + LEN_W + 2 * ADDR_W;

  logic [IDX_W-1:0] wr_q, rd_q, lw_q, off_q, db_q, rd_idx_q;
  logic [IDX_W-1:0] wr_nxt;
  logic [CNT_W-1:0] sub_q;
  logic             dbv_q, accept, do_sub;
  logic [DATA_W-1:0] wdata, rdata;

  assign cap_o      = MASK + rd_q - wr_q;
  assign accept     = req_valid_i && (cap_o != '0);
  assign req_ok_o   = accept;
  assign req_full_o = req_valid_i && (cap_o == '0);
  assign req_idx_o  = wr_q;
  assign wr_nxt     = accept ? wr_q + 1'b1 : wr_q;
  assign do_sub     = (accept && req_submit_i) || submit_i;

  // completion-update bit is always set
  assign wdata = {req_op_i, 1'b1, req_len_i, req_src_i, req_dst_i};

  dring_ram #(.DEPTH(RING_N), .AW(RING_AW), .DATA_W(DATA_W)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (accept),
    .waddr_i  (wr_q[RING_AW-1:0]),
    .wdata_i  (wdata),
    .fset_i   (accept && req_fence_i),
    .faddr_i  (RING_AW'(wr_q - 1'b1)),
    .raddr_i  (rd_idx_i[RING_AW-1:0]),
    .rdata_o  (rdata),
    .rfence_o (rd_fence_o)
  );

  dring_retire #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RING_BASE(RING_BASE), .MASK(MASK)) u_retire (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (cmp_status_i),
    .offset_i (off_q),
    .read_i   (rd_q),
    .max_i    (cmp_max_i),
    .count_o  (cmp_count_o),
    .last_o   (cmp_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= '0;
      rd_q     <= '0;
      lw_q     <= '0;
      off_q    <= '0;
      db_q     <= '0;
      dbv_q    <= 1'b0;
      sub_q    <= '0;
      rd_idx_q <= '0;
    end else begin
      wr_q     <= wr_nxt;
      dbv_q    <= do_sub;
      rd_idx_q <= rd_idx_i & MASK;
      if (do_sub) begin
        db_q  <= wr_nxt - off_q;
        sub_q <= sub_q + CNT_W'(IDX_W'(wr_nxt - lw_q));
        lw_q  <= wr_nxt;
      end
      if (cmp_valid_i) rd_q  <= rd_q + cmp_count_o;
      if (recover_i)   off_q <= rd_q;
    end
  end

  assign db_valid_o = dbv_q;
  assign db_count_o = db_q;
  assign sub_cnt_o  = sub_q;
  assign {rd_op_o, rd_comp_o, rd_len_o, rd_src_o, rd_dst_o} = rdata;
  assign rd_next_o  = RING_BASE + (ADDR_W'((rd_idx_q + 1'b1) & MASK) << DESC_SHIFT);

  a_r3_cap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o <= MASK);
  a_r3_full_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_full_o |-> !req_ok_o);
  a_r6_db_follows_submit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    submit_i |=> db_valid_o);
  a_r9_write_steps_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok_o |=> (wr_q == $past(wr_q) + 1'b1));
endmodule

// File: tb/dring_producer_test.sv
module dring_producer_test;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_op = 0, req_fence = 0, req_submit = 0;
  logic [31:0] req_src = 0, req_dst = 0;
  logic [15:0] req_len = 0;
  logic        submit = 0, recover = 0, cmp_valid = 0;
  logic [31:0] cmp_status = 0;
  logic [15:0] cmp_max = 0, rd_idx = 0;
  logic        req_ok, req_full, db_valid, rd_op, rd_comp, rd_fence;
  logic [15:0] req_idx, db_count, cap, cmp_count, cmp_last, rd_len;
  logic [31:0] sub_cnt, rd_src, rd_dst, rd_next;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dring_producer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_src_i(req_src), .req_dst_i(req_dst),
    .req_len_i(req_len), .req_fence_i(req_fence), .req_submit_i(req_submit),
    .req_ok_o(req_ok), .req_full_o(req_full), .req_idx_o(req_idx),
    .submit_i(submit), .recover_i(recover),
    .db_valid_o(db_valid), .db_count_o(db_count), .sub_cnt_o(sub_cnt), .cap_o(cap),
    .cmp_valid_i(cmp_valid), .cmp_status_i(cmp_status), .cmp_max_i(cmp_max),
    .cmp_count_o(cmp_count), .cmp_last_o(cmp_last),
    .rd_idx_i(rd_idx), .rd_op_o(rd_op), .rd_comp_o(rd_comp), .rd_fence_o(rd_fence),
    .rd_len_o(rd_len), .rd_src_o(rd_src), .rd_dst_o(rd_dst), .rd_next_o(rd_next)
  );

  typedef struct packed {
    logic        op;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] len;
    logic        sub;
    logic [15:0] idx;
    logic [15:0] cap;
    logic [15:0] db;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0000_1000, 32'h0000_2000, 16'd64,  1'b0, 16'd0, 16'd30, 16'd0},
    '{1'b1, 32'hA5A5_A5A5, 32'h0000_3000, 16'd128, 1'b1, 16'd1, 16'd29, 16'd2},
    '{1'b0, 32'h0000_1100, 32'h0000_2100, 16'd32,  1'b0, 16'd2, 16'd28, 16'd0},
    '{1'b1, 32'h5A5A_0F0F, 32'h0000_3100, 16'd256, 1'b0, 16'd3, 16'd27, 16'd0},
    '{1'b0, 32'h0000_1200, 32'h0000_2200, 16'd16,  1'b1, 16'd4, 16'd26, 16'd5},
    '{1'b0, 32'h0000_1300, 32'h0000_2300, 16'd8,   1'b0, 16'd5, 16'd25, 16'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic        s_ok, s_full;
  logic [15:0] s_idx, s_cnt, s_last;

  // called at a negedge; returns at the negedge after the commit edge
  task automatic do_req(input logic op, input logic [31:0] src, input logic [31:0] dst,
                        input logic [15:0] len, input logic fence, input logic sub);
    req_valid = 1; req_op = op; req_src = src; req_dst = dst; req_len = len;
    req_fence = fence; req_submit = sub;
    #1 s_ok = req_ok; s_full = req_full; s_idx = req_idx;
    @(negedge clk);
    req_valid = 0; req_fence = 0; req_submit = 0;
  endtask

  task automatic do_read(input logic [15:0] idx);
    rd_idx = idx;
    @(negedge clk);
  endtask

  task automatic do_cmp(input logic [31:0] st, input logic [15:0] mx);
    cmp_valid = 1; cmp_status = st; cmp_max = mx;
    #1 s_cnt = cmp_count; s_last = cmp_last;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic pulse_submit();
    submit = 1;
    @(negedge clk);
    submit = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, rounding 24 -> 32
    chk("R1 reset cap", cap, 31);
    chk("R6 reset db_valid", db_valid, 0);
    chk("R6 reset sub_cnt", sub_cnt, 0);

    foreach (VECS[k]) begin
      do_req(VECS[k].op, VECS[k].src, VECS[k].dst, VECS[k].len, 1'b0, VECS[k].sub);
      chk("R9 vec ok", s_ok, 1);
      chk("R9 vec idx", s_idx, VECS[k].idx);
      chk("R3 vec cap", cap, VECS[k].cap);
      chk("R10 vec db_valid", db_valid, VECS[k].db != 0);
      if (VECS[k].db != 0) chk("R10 vec db_count", db_count, VECS[k].db);
    end
    chk("R6 sub_cnt after vectors", sub_cnt, 5);

    do_read(1);
    chk("R4 fill op", rd_op, 1);
    chk("R4 fill pattern in src", rd_src, 32'hA5A5_A5A5);
    chk("R4 comp bit", rd_comp, 1);
    chk("R4 len", rd_len, 128);
    chk("R2 next slot1", rd_next, BASE + 2 * 64);
    do_read(2);
    chk("R4 copy op", rd_op, 0);
    chk("R4 copy dst", rd_dst, 32'h0000_2100);
    do_read(31);
    chk("R2 last slot wraps", rd_next, BASE);

    // fence goes onto the previous slot
    do_req(1'b0, 32'h0000_1400, 32'h0000_2400, 16'd4, 1'b1, 1'b0);
    chk("R9 fenced idx", s_idx, 6);
    do_read(5);
    chk("R5 prev fence set", rd_fence, 1);
    do_read(6);
    chk("R5 own fence clear", rd_fence, 0);

    pulse_submit();
    chk("R6 standalone db", db_valid, 1);
    chk("R6 db count", db_count, 7);
    chk("R6 sub_cnt grows", sub_cnt, 7);
    pulse_submit();
    chk("R6 repeat sub_cnt", sub_cnt, 7);

    // completions
    do_cmp(BASE + 3 * 64 + 1, 16);
    chk("R8 count", s_cnt, 4);
    chk("R7 last", s_last, 3);
    chk("R3 cap after retire", cap, 28);
    do_cmp(BASE + 6 * 64, 2);
    chk("R8 count capped", s_cnt, 2);
    chk("R8 last capped", s_last, 5);
    chk("R3 cap", cap, 30);

    // fill to full
    for (int i = 0; i < 30; i++) begin
      do_req(1'b0, 32'h0000_8000 + i, 32'h0000_9000, 16'd1, 1'b0, 1'b0);
      if (!s_ok) chk("R3 fill accepted", s_ok, 1);
    end
    chk("R3 cap zero", cap, 0);
    do_req(1'b1, 32'hDEAD_BEEF, 32'h0, 16'd9, 1'b1, 1'b1);
    chk("R3 full flag", s_full, 1);
    chk("R3 rejected", s_ok, 0);
    chk("R3 no doorbell on reject", db_valid, 0);
    chk("R3 cap still zero", cap, 0);
    do_read(5);
    chk("R3 slot untouched", rd_src, 32'h0000_1300);
    do_read(4);
    chk("R3 no fence on reject", rd_fence, 0);

    // recovery
    recover = 1;
    @(negedge clk);
    recover = 0;
    pulse_submit();
    chk("R11 db from offset", db_count, 31);
    do_cmp(32'h0000_0002, 32);
    chk("R7 zero status count", s_cnt, 0);
    chk("R7 zero status last", s_last, 5);
    do_cmp(BASE + 10 * 64, 32);
    chk("R8 count after recovery", s_cnt, 5);
    chk("R3 cap freed", cap, 5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule